// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts a 32-bit virtual address into one of a handful of address segments and decides, within the same cycle, how the physical address is formed. Two fixed kernel windows in the upper half of the address space bypass translation: each one drops a constant base from the address. One window is tagged cacheable and the other uncacheable. The lower half of the space and the top quarter go to the translation lookaside buffer (TLB). The block presents the address on a lookup port and folds the TLB's answer back into its outputs.

Three further rules apply. A user-mode access to any address with the top bit set raises an address error, and that error overrides every other result. While the error-level flag is raised, the lower half is not translated: the physical address equals the virtual address. The block is purely combinational. It sits between the address generation stage and the memory access stage of a load/store pipe, and the pipe supplies any register stages around it.

Top module: `vaseg_decoder`

## Requirements
- R1: When `user_mode_i` is 1 and `vaddr_i[31]` is 1, `addr_err_o` is 1, `tlb_req_o` is 0, and `paddr_o`, `perm_o`, `fault_o` and `cached_o` are all 0, whatever the TLB inputs are.
- R2: For an address below 0x80000000 with `err_level_i` at 0, `tlb_req_o` is 1, and the user-mode flag does not change the result.
- R3: For an address below 0x80000000 with `err_level_i` at 1, `tlb_req_o` is 0, `paddr_o` equals `vaddr_i`, `cached_o` is 0, `perm_o` is 2'b11 and `fault_o` is 0.
- R4: For addresses 0x80000000 to 0x9FFFFFFF (not in error), `paddr_o` is the address minus 0x80000000, `cached_o` is 1, `perm_o` is 2'b11, `fault_o` is 0 and `tlb_req_o` is 0.
- R5: For addresses 0xA0000000 to 0xBFFFFFFF (not in error), `paddr_o` is the address minus 0xA0000000, `cached_o` is 0, `perm_o` is 2'b11, `fault_o` is 0 and `tlb_req_o` is 0.
- R6: Addresses from 0xC0000000 up, outside user mode, assert `tlb_req_o`, and `err_level_i` has no effect on them.
- R7: While `tlb_req_o` is 1, `fault_o` equals `tlb_fault_i` unchanged. The encoding is 0 for no fault, 1 for no matching entry, 2 for an entry not valid, and 3 for a write to a clean page. A nonzero code forces `paddr_o`, `perm_o` and `cached_o` to 0.
- R8: While `tlb_req_o` is 1 and `tlb_fault_i` is 0, `paddr_o` equals `tlb_paddr_i`, `cached_o` equals `tlb_cached_i`, and `perm_o` equals `tlb_perm_i`. Bit 1 of the permission field is read and bit 0 is write.
- R9: `tlb_vaddr_o` always equals `vaddr_i`. In the unmapped segments the TLB inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr_i | input | 32 | Virtual address to decode |
| user_mode_i | input | 1 | Access issued in user mode |
| err_level_i | input | 1 | Error-level flag; low half becomes identity-mapped |
| tlb_paddr_i | input | 32 | Physical address returned by the TLB |
| tlb_fault_i | input | 2 | TLB fault code (0 none, 1 miss, 2 invalid, 3 clean page written) |
| tlb_perm_i | input | 2 | TLB permission, bit 1 read, bit 0 write |
| tlb_cached_i | input | 1 | TLB cacheability tag |
| tlb_req_o | output | 1 | Address is mapped and goes to the TLB |
| tlb_vaddr_o | output | 32 | Address presented on the lookup port |
| paddr_o | output | 32 | Resulting physical address |
| perm_o | output | 2 | Resulting permission, bit 1 read, bit 0 write |
| fault_o | output | 2 | Resulting fault code |
| cached_o | output | 1 | 1 when the access is cacheable |
| addr_err_o | output | 1 | Address error for a user access to the upper half |

## Verification
The block holds no state. A wrong internal segment decision therefore shows up at the ports in the same cycle as the address that provokes it. It appears as a wrong `tlb_req_o`, as a physical address off by a window base, or as a cacheability tag swapped between the two kernel windows. The stimulus works the segment edges hardest: 0x7FFFFFFF/0x80000000, 0x9FFFFFFF/0xA0000000 and 0xBFFFFFFF/0xC0000000. At each edge the user and error-level flags are toggled, because a misplaced compare or a wrong flag priority only shows there. A full sweep of the fault codes in a mapped segment checks that the codes pass through and that a fault blanks the translated outputs.

// File: rtl/vaseg_pkg.sv
// Shared types for the virtual address segment decoder.
// Assumes a 2-bit fault code and a 2-bit permission field.
package vaseg_pkg;

    // Segment class chosen for one address
    typedef enum logic [2:0] {
        SEG_LOW_MAPPED   = 3'd0,
        SEG_LOW_IDENT    = 3'd1,
        SEG_KWIN_CACHED  = 3'd2,
        SEG_KWIN_UNCACH  = 3'd3,
        SEG_HIGH_MAPPED  = 3'd4,
        SEG_ADDR_ERR     = 3'd5
    } seg_e;

    // Translation fault code, passed through from the TLB
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_CLEAN   = 2'd3
    } fault_e;

    localparam logic [1:0] PERM_RW   = 2'b11;
    localparam logic [1:0] PERM_NONE = 2'b00;

endpackage

// File: rtl/vaseg_classify.sv
// Classifies a virtual address into a segment.
// Assumes the segment is decided by the top three address bits only.
module vaseg_classify
    import vaseg_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            user_mode,
    input  logic            err_level,
    output seg_e            seg
);
    localparam int TOP = VA_W - 1;

    // Segment decision: privilege check first, then address range
    always_comb begin
        if (user_mode && vaddr[TOP]) begin
            seg = SEG_ADDR_ERR;
        end else if (!vaddr[TOP]) begin
            seg = err_level ? SEG_LOW_IDENT : SEG_LOW_MAPPED;
        end else begin
            case (vaddr[TOP-1:TOP-2])
                2'b00:   seg = SEG_KWIN_CACHED;
                2'b01:   seg = SEG_KWIN_UNCACH;
                default: seg = SEG_HIGH_MAPPED;
            endcase
        end
    end

    // Consistency of the class with the address bit it came from
    always_comb begin
        AST_SEG_HALF: assert (seg == SEG_ADDR_ERR || (seg == SEG_LOW_MAPPED || seg == SEG_LOW_IDENT) == !vaddr[TOP])
            else $error("segment class disagrees with address half"); // R2
    end
endmodule

// File: rtl/vaseg_window.sv
// Forms the physical address for the unmapped segments.
// Assumes both kernel windows are aligned to their own size, so
// subtracting the base equals clearing the selecting bits.
module vaseg_window
    import vaseg_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int SEL_BITS = 3
) (
    input  logic [VA_W-1:0] vaddr,
    input  seg_e            seg,
    output logic [VA_W-1:0] paddr
);
    localparam int OFF_W = VA_W - SEL_BITS;
    localparam logic [VA_W-1:0] BASE_CACHED = {3'b100, {OFF_W{1'b0}}};
    localparam logic [VA_W-1:0] BASE_UNCACH = {3'b101, {OFF_W{1'b0}}};

    logic [VA_W-1:0] base;

    // Pick the base that the current segment removes
    always_comb begin
        case (seg)
            SEG_KWIN_CACHED: base = BASE_CACHED;
            SEG_KWIN_UNCACH: base = BASE_UNCACH;
            default:         base = '0;
        endcase
    end

    // Unmapped physical address: address with window base removed
    assign paddr = vaddr - base;

    // A window result never reaches above the window size
    always_comb begin
        AST_WIN_RANGE: assert (!(seg == SEG_KWIN_CACHED || seg == SEG_KWIN_UNCACH) || paddr[VA_W-1:OFF_W] == '0)
            else $error("window address exceeds window size"); // R4
    end
endmodule

// File: rtl/vaseg_merge.sv
// Chooses between the unmapped result, the TLB answer and the
// address error for each output field.
// Assumes the address error outranks every TLB result.
module vaseg_merge
    import vaseg_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  seg_e            seg,
    input  logic [PA_W-1:0] win_paddr,
    input  logic [PA_W-1:0] tlb_paddr,
    input  logic [1:0]      tlb_fault,
    input  logic [1:0]      tlb_perm,
    input  logic            tlb_cached,
    output logic            mapped,
    output logic            addr_err,
    output logic [PA_W-1:0] paddr,
    output logic [1:0]      perm,
    output logic [1:0]      fault,
    output logic            cached
);
    // Output selection per segment class
    always_comb begin
        mapped   = 1'b0;
        addr_err = 1'b0;
        paddr    = '0;
        perm     = PERM_NONE;
        fault    = FLT_NONE;
        cached   = 1'b0;
        case (seg)
            SEG_ADDR_ERR: addr_err = 1'b1;
            SEG_LOW_IDENT, SEG_KWIN_UNCACH: begin
                paddr = win_paddr;
                perm  = PERM_RW;
            end
            SEG_KWIN_CACHED: begin
                paddr  = win_paddr;
                perm   = PERM_RW;
                cached = 1'b1;
            end
            default: begin
                mapped = 1'b1;
                fault  = tlb_fault;
                if (tlb_fault == FLT_NONE) begin
                    paddr  = tlb_paddr;
                    perm   = tlb_perm;
                    cached = tlb_cached;
                end
            end
        endcase
    end
endmodule

// File: rtl/vaseg_decoder.sv
// Top of the virtual address segment decoder. Purely combinational:
// classify, form the unmapped address, merge with the TLB answer.
// Assumes the caller registers inputs and outputs as its pipe needs.
module vaseg_decoder
    import vaseg_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  logic            user_mode_i,
    input  logic            err_level_i,
    input  logic [VA_W-1:0] tlb_paddr_i,
    input  logic [1:0]      tlb_fault_i,
    input  logic [1:0]      tlb_perm_i,
    input  logic            tlb_cached_i,
    output logic            tlb_req_o,
    output logic [VA_W-1:0] tlb_vaddr_o,
    output logic [VA_W-1:0] paddr_o,
    output logic [1:0]      perm_o,
    output logic [1:0]      fault_o,
    output logic            cached_o,
    output logic            addr_err_o
);
    localparam int TOP = VA_W - 1;

    seg_e            seg;
    logic [VA_W-1:0] win_paddr;

    vaseg_classify #(.VA_W(VA_W)) u_classify (
        .vaddr     (vaddr_i),
        .user_mode (user_mode_i),
        .err_level (err_level_i),
        .seg       (seg)
    );

    vaseg_window #(.VA_W(VA_W), .SEL_BITS(3)) u_window (
        .vaddr (vaddr_i),
        .seg   (seg),
        .paddr (win_paddr)
    );

    vaseg_merge #(.PA_W(VA_W)) u_merge (
        .seg        (seg),
        .win_paddr  (win_paddr),
        .tlb_paddr  (tlb_paddr_i),
        .tlb_fault  (tlb_fault_i),
        .tlb_perm   (tlb_perm_i),
        .tlb_cached (tlb_cached_i),
        .mapped     (tlb_req_o),
        .addr_err   (addr_err_o),
        .paddr      (paddr_o),
        .perm       (perm_o),
        .fault      (fault_o),
        .cached     (cached_o)
    );

    // Lookup port always carries the incoming address
    assign tlb_vaddr_o = vaddr_i;

    // Port-level rules across the three submodules
    always_comb begin
        AST_USER_HIGH_ERR: assert (!(user_mode_i && vaddr_i[TOP]) || (addr_err_o && !tlb_req_o))
            else $error("user access to upper half not flagged"); // R1
        AST_ERR_QUIET: assert (!addr_err_o || (paddr_o == '0 && perm_o == 2'b00 && fault_o == 2'b00 && !cached_o))
            else $error("address error leaks a result"); // R1
        AST_IDENT_PASS: assert (!(!vaddr_i[TOP] && err_level_i) || (paddr_o == vaddr_i && !tlb_req_o))
            else $error("error-level bypass not identity"); // R3
        AST_UNMAPPED_RW: assert (tlb_req_o || addr_err_o || (perm_o == 2'b11 && fault_o == 2'b00))
            else $error("unmapped access lacks full permission"); // R4
        AST_FAULT_PASS: assert (!tlb_req_o || fault_o == tlb_fault_i)
            else $error("fault code altered"); // R7
        AST_FAULT_BLANK: assert (fault_o == 2'b00 || (paddr_o == '0 && perm_o == 2'b00))
            else $error("faulted access carries an address"); // R7
    end
endmodule

// File: tb/tb_vaseg_decoder.sv
module tb_vaseg_decoder;

    typedef struct packed {
        logic [31:0] va;
        logic        um;
        logic        el;
        logic [31:0] tpa;
        logic [1:0]  tf;
        logic [1:0]  tp;
        logic        tc;
        logic [7:0]  rq;
    } vec_t;

    typedef struct packed {
        logic        req;
        logic        err;
        logic        cac;
        logic [1:0]  prm;
        logic [1:0]  flt;
        logic [31:0] pa;
        logic [31:0] tva;
    } res_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 1'b0, 1'b0, 32'h1234_5000, 2'd0, 2'b10, 1'b1, 8'd2},  // R2 kernel low mapped
        '{32'h7FFF_FFFF, 1'b1, 1'b0, 32'h0ABC_DFFF, 2'd0, 2'b11, 1'b0, 8'd2},  // R2 user top of low half
        '{32'h7FFF_FFFF, 1'b1, 1'b1, 32'h0ABC_DFFF, 2'd1, 2'b11, 1'b1, 8'd3},  // R3 user, error level
        '{32'h0000_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd2, 2'b01, 1'b1, 8'd3},  // R3 zero identity, TLB ignored
        '{32'h8000_0000, 1'b1, 1'b0, 32'h1111_1111, 2'd0, 2'b11, 1'b1, 8'd1},  // R1 first upper address
        '{32'hFFFF_FFFF, 1'b1, 1'b1, 32'h2222_2222, 2'd3, 2'b11, 1'b1, 8'd1},  // R1 last address
        '{32'hA123_4567, 1'b1, 1'b0, 32'h3333_3333, 2'd0, 2'b11, 1'b1, 8'd1},  // R1 uncached window
        '{32'h8000_0000, 1'b0, 1'b0, 32'h4444_4444, 2'd1, 2'b00, 1'b0, 8'd4},  // R4 window start
        '{32'h9FFF_FFFF, 1'b0, 1'b1, 32'h4444_4444, 2'd0, 2'b00, 1'b0, 8'd4},  // R4 window end, error level
        '{32'h8765_4321, 1'b0, 1'b0, 32'h0000_0000, 2'd3, 2'b01, 1'b1, 8'd9},  // R9 TLB ignored in window
        '{32'hA000_0000, 1'b0, 1'b0, 32'h5555_5555, 2'd0, 2'b11, 1'b1, 8'd5},  // R5 window start
        '{32'hBFFF_FFFF, 1'b0, 1'b1, 32'h5555_5555, 2'd2, 2'b11, 1'b1, 8'd5},  // R5 window end
        '{32'hC000_0000, 1'b0, 1'b0, 32'h0001_0000, 2'd0, 2'b01, 1'b1, 8'd6},  // R6 first mapped high
        '{32'hC000_0000, 1'b0, 1'b1, 32'h0001_0000, 2'd0, 2'b01, 1'b1, 8'd6},  // R6 error level no effect
        '{32'hFFFF_F000, 1'b0, 1'b1, 32'h0F00_0000, 2'd0, 2'b10, 1'b0, 8'd8},  // R8 top page
        '{32'hE000_0010, 1'b0, 1'b0, 32'h0BAD_0010, 2'd1, 2'b11, 1'b1, 8'd7},  // R7 miss
        '{32'hE000_0010, 1'b0, 1'b0, 32'h0BAD_0010, 2'd2, 2'b11, 1'b1, 8'd7},  // R7 invalid
        '{32'h1000_0010, 1'b0, 1'b0, 32'h0BAD_0010, 2'd3, 2'b11, 1'b1, 8'd7},  // R7 clean page written
        '{32'h4000_0000, 1'b0, 1'b0, 32'h7777_0000, 2'd0, 2'b01, 1'b0, 8'd8},  // R8 write-only grant
        '{32'h3FFF_FFFF, 1'b1, 1'b0, 32'h7777_0FFF, 2'd0, 2'b10, 1'b1, 8'd8}   // R8 user low, read-only
    };

    logic        clk;
    logic [31:0] vaddr;
    logic        umode, elvl;
    logic [31:0] tpa;
    logic [1:0]  tflt, tprm;
    logic        tcac;
    logic        req, err, cac;
    logic [31:0] pa, tva;
    logic [1:0]  prm, flt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    vaseg_decoder dut (
        .vaddr_i      (vaddr),
        .user_mode_i  (umode),
        .err_level_i  (elvl),
        .tlb_paddr_i  (tpa),
        .tlb_fault_i  (tflt),
        .tlb_perm_i   (tprm),
        .tlb_cached_i (tcac),
        .tlb_req_o    (req),
        .tlb_vaddr_o  (tva),
        .paddr_o      (pa),
        .perm_o       (prm),
        .fault_o      (flt),
        .cached_o     (cac),
        .addr_err_o   (err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Expected outputs written from the requirement list
    function automatic res_t expect_of(vec_t v);
        res_t e = '0;
        e.tva = v.va;                                        // R9
        if (v.um && v.va[31]) begin
            e.err = 1'b1;                                    // R1
        end else if (!v.va[31] && v.el) begin
            e.pa = v.va; e.prm = 2'b11;                      // R3
        end else if (v.va >= 32'h8000_0000 && v.va <= 32'h9FFF_FFFF) begin
            e.pa = v.va - 32'h8000_0000; e.prm = 2'b11; e.cac = 1'b1;  // R4
        end else if (v.va >= 32'hA000_0000 && v.va <= 32'hBFFF_FFFF) begin
            e.pa = v.va - 32'hA000_0000; e.prm = 2'b11;      // R5
        end else begin
            e.req = 1'b1; e.flt = v.tf;                      // R2 R6 R7
            if (v.tf == 2'd0) begin
                e.pa = v.tpa; e.prm = v.tp; e.cac = v.tc;    // R8
            end
        end
        return e;
    endfunction

    task automatic apply_check(vec_t v);
        res_t got, exp;
        @(posedge clk);
        vaddr = v.va; umode = v.um; elvl = v.el;
        tpa = v.tpa; tflt = v.tf; tprm = v.tp; tcac = v.tc;
        @(negedge clk);
        got = '{req, err, cac, prm, flt, pa, tva};
        exp = expect_of(v);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d va=%h got=%h exp=%h", v.rq, v.va, got, exp);
        end
    endtask

    initial begin
        vec_t v;
        vaddr = '0; umode = 0; elvl = 0; tpa = '0; tflt = '0; tprm = '0; tcac = 0;
        // Reset-state check: all-zero inputs give a mapped, fault-free lookup (R2)
        v = '{32'h0, 1'b0, 1'b0, 32'h0, 2'd0, 2'b00, 1'b0, 8'd2};
        apply_check(v);
        for (int i = 0; i < NV; i++) apply_check(VECS[i]);
        // R7: every fault code at the mapped high boundary
        for (int f = 0; f < 4; f++) begin
            v = '{32'hC000_0ABC, 1'b0, 1'b0, 32'h00AB_CABC, f[1:0], 2'b11, 1'b1, 8'd7};
            apply_check(v);
        end
        // R9: TLB inputs toggled in both kernel windows and the identity half
        for (int k = 0; k < 3; k++) begin
            v = '{(k == 0) ? 32'h9000_0040 : (k == 1) ? 32'hB000_0040 : 32'h5000_0040,
                  1'b0, 1'b1, 32'hDEAD_BEEF, 2'd3, 2'b00, 1'b1, 8'd9};
            apply_check(v);
        end
        // R1: address error outranks a clean TLB hit at 0xC0000000
        v = '{32'hC000_0000, 1'b1, 1'b0, 32'h1234_0000, 2'd0, 2'b11, 1'b1, 8'd1};
        apply_check(v);
        done = 1;
    end

    // Watchdog and summary
    initial begin
        int cyc = 0;
        while (!done && cyc < 10000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule